// File: doc/BRIEF.md
# Floating-Point Register File with NaN Boxing

This block holds the floating-point architectural registers of a core: 32 entries, each `FLEN` bits wide, where `FLEN` is 32 or 64. One write port and two read ports each carry a format code selecting half (16-bit), single (32-bit) or double (64-bit) precision. Values travel low-justified on the data buses.

Writing a value narrower than `FLEN` fills every bit above it with ones. The stored word therefore looks like a quiet NaN to any wider reader. A read of a narrower format checks those upper bits. If they are all ones, the low bits are returned. If not, the read returns that format's canonical NaN. A format as wide as `FLEN` passes through both ways untouched. A format wider than `FLEN`, or the reserved code, raises an error flag on its port. A write with that error leaves the registers unchanged.

Writes land on the rising clock edge and reads are combinational, so a read of the register being written in the same cycle sees the old contents. Reset is synchronous and active-high.

Top module: `fpreg_file`

## Requirements
- R1: A cycle with `rst` high sets every register to all ones. Afterwards a half read returns 0xFFFF, a single read returns 0xFFFFFFFF, and a double read (FLEN=64) returns all ones.
- R2: A half write (format code 0) stores `wr_data[15:0]` with ones in every bit above 15. Bits of `wr_data` above bit 15 are ignored.
- R3: With FLEN=64, a single write (format code 1) stores `wr_data[31:0]` with ones in bits 63..32.
- R4: A read of a format narrower than `FLEN` returns the register's low bits when every bit above the format width is one. Read data bits above the format width are zero.
- R5: A narrower read whose upper bits are not all ones returns the canonical NaN of the requested format: 0x7E00 for half, 0x7FC00000 for single.
- R6: A format whose width equals `FLEN` is written and read unchanged, with no boxing and no check.
- R7: Format code 2 is double and code 3 is reserved. A port whose code is 3, or whose format is wider than `FLEN`, raises its error output. A read port with that error drives zero data.
- R8: A write with its error raised changes no register.
- R9: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the previous contents.
- R10: The two read ports work independently, each with its own index and format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 2 | Write format: 0 half, 1 single, 2 double, 3 reserved |
| wr_data | input | FLEN | Low-justified write value |
| wr_err | output | 1 | Write format illegal (only while `wr_en` is high) |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_fmt | input | 2 | Read port 0 format |
| rd0_data | output | FLEN | Read port 0 value, zero above the format width |
| rd0_err | output | 1 | Read port 0 format illegal |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_fmt | input | 2 | Read port 1 format |
| rd1_data | output | FLEN | Read port 1 value, zero above the format width |
| rd1_err | output | 1 | Read port 1 format illegal |

## Verification
The bench runs at FLEN=64 and writes and reads the same register in different formats. Each directed pairing targets one rule:
- A half write read as single tells a correct box-and-pass from a missing box.
- A single write read as half, and a double write read as single, must both produce canonical NaNs.
- A double with ones in its upper bits read as half must pass, which shows the check looks only at bits above the format width.

Random writes and reads in all four format codes, mixed with random garbage in the unused data bits, are compared against a shadow model of the boxing rules. Same-cycle read-during-write and illegal writes are driven on purpose.

// File: rtl/fpreg_pkg.sv
package fpreg_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    localparam int MAX_W = 64;

    // Width in bits of each format; reserved code reports a width no FLEN admits.
    function automatic int fmt_bits(fmt_e f);
        case (f)
            FMT_HALF:   return 16;
            FMT_SINGLE: return 32;
            FMT_DOUBLE: return 64;
            default:    return 128;
        endcase
    endfunction

    function automatic logic fmt_legal(fmt_e f, int flen);
        return (f != FMT_RSVD) && (fmt_bits(f) <= flen);
    endfunction

    // Ones over the bits the format occupies.
    function automatic logic [MAX_W-1:0] fmt_mask(fmt_e f);
        case (f)
            FMT_HALF:   return {{48{1'b0}}, {16{1'b1}}};
            FMT_SINGLE: return {{32{1'b0}}, {32{1'b1}}};
            default:    return {MAX_W{1'b1}};
        endcase
    endfunction

    // Quiet NaN with clear sign, low-justified: exponent ones, top fraction bit set.
    function automatic logic [MAX_W-1:0] fmt_canon(fmt_e f);
        case (f)
            FMT_HALF:   return {{48{1'b0}}, 1'b0, {5{1'b1}}, 1'b1, {9{1'b0}}};
            FMT_SINGLE: return {{32{1'b0}}, 1'b0, {8{1'b1}}, 1'b1, {22{1'b0}}};
            default:    return {1'b0, {11{1'b1}}, 1'b1, {51{1'b0}}};
        endcase
    endfunction

endpackage

// File: rtl/fpreg_boxer.sv
module fpreg_boxer
    import fpreg_pkg::*;
#(
    parameter int FLEN = 32
) (
    input  fmt_e            fmt,
    input  logic [FLEN-1:0] din,
    output logic [FLEN-1:0] dout,
    output logic            legal
);
    logic [MAX_W-1:0] m64;
    logic [FLEN-1:0]  mask;

    always_comb begin
        m64   = fmt_mask(fmt);
        mask  = m64[FLEN-1:0];
        legal = fmt_legal(fmt, FLEN);
        dout  = din | ~mask;
    end

    always_comb begin
        if (legal) begin
            AST_BOX_PAYLOAD_KEPT: assert ((dout & mask) == (din & mask)); // R2
            AST_BOX_UPPER_ONES: assert (&(dout | mask));                  // R3
        end
    end
endmodule

// File: rtl/fpreg_unboxer.sv
module fpreg_unboxer
    import fpreg_pkg::*;
#(
    parameter int FLEN = 32
) (
    input  fmt_e            fmt,
    input  logic [FLEN-1:0] word,
    output logic [FLEN-1:0] dout,
    output logic            err
);
    logic [MAX_W-1:0] m64;
    logic [MAX_W-1:0] c64;
    logic [FLEN-1:0]  mask;
    logic [FLEN-1:0]  canon;
    logic             boxed_ok;

    always_comb begin
        m64      = fmt_mask(fmt);
        c64      = fmt_canon(fmt);
        mask     = m64[FLEN-1:0];
        canon    = c64[FLEN-1:0];
        err      = !fmt_legal(fmt, FLEN);
        // Full-width formats have an all-ones mask, so the check always passes.
        boxed_ok = &(word | mask);
        if (err)
            dout = '0;
        else if (boxed_ok)
            dout = word & mask;
        else
            dout = canon & mask;
    end

    always_comb begin
        if (err) begin
            AST_ERR_ZERO_DATA: assert (dout == '0);                                  // R7
        end else begin
            AST_NO_BITS_ABOVE: assert ((dout & ~mask) == '0);                        // R4
            AST_PASS_OR_CANON: assert (dout == (word & mask) || dout == (canon & mask)); // R5
        end
    end
endmodule

// File: rtl/fpreg_storage.sv
module fpreg_storage #(
    parameter int FLEN = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDXW-1:0]           widx,
    input  logic [FLEN-1:0]           wdata,
    input  logic [NRD-1:0][IDXW-1:0]  ridx,
    output logic [NRD-1:0][FLEN-1:0]  rdata
);
    logic [FLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '1;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[ridx[p]];
    end

    AST_RESET_ALL_ONES: assert property (@(posedge clk)
        $past(rst) && !rst |-> (mem[0] == '1) && (mem[NREG-1] == '1)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !we |=> mem[$past(widx)] == $past(mem[widx])); // R8
endmodule

// File: rtl/fpreg_file.sv
module fpreg_file
    import fpreg_pkg::*;
#(
    parameter int FLEN = 32,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int NRD  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_fmt,
    input  logic [FLEN-1:0] wr_data,
    output logic            wr_err,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_fmt,
    output logic [FLEN-1:0] rd0_data,
    output logic            rd0_err,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_fmt,
    output logic [FLEN-1:0] rd1_data,
    output logic            rd1_err
);
    logic [FLEN-1:0]            boxed;
    logic                       wr_legal;
    logic                       store_we;
    logic [NRD-1:0][IDXW-1:0]   r_idx;
    logic [NRD-1:0][1:0]        r_fmt;
    logic [NRD-1:0][FLEN-1:0]   r_word;
    logic [NRD-1:0][FLEN-1:0]   r_out;
    logic [NRD-1:0]             r_err;

    fpreg_boxer #(.FLEN(FLEN)) u_box (
        .fmt   (fmt_e'(wr_fmt)),
        .din   (wr_data),
        .dout  (boxed),
        .legal (wr_legal)
    );

    assign store_we = wr_en && wr_legal;
    assign wr_err   = wr_en && !wr_legal;

    assign r_idx = {rd1_idx, rd0_idx};
    assign r_fmt = {rd1_fmt, rd0_fmt};

    fpreg_storage #(.FLEN(FLEN), .NREG(NREG), .NRD(NRD)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .widx  (wr_idx),
        .wdata (boxed),
        .ridx  (r_idx),
        .rdata (r_word)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        fpreg_unboxer #(.FLEN(FLEN)) u_unbox (
            .fmt  (fmt_e'(r_fmt[p])),
            .word (r_word[p]),
            .dout (r_out[p]),
            .err  (r_err[p])
        );
    end

    assign rd0_data = r_out[0];
    assign rd1_data = r_out[1];
    assign rd0_err  = r_err[0];
    assign rd1_err  = r_err[1];

    AST_ERR_BLOCKS_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> !store_we); // R8
endmodule

// File: tb/fpreg_file_tb.sv
module fpreg_file_tb;
    localparam int FLEN = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en;
    logic [4:0]      wr_idx;
    logic [1:0]      wr_fmt;
    logic [FLEN-1:0] wr_data;
    logic            wr_err;
    logic [4:0]      rd0_idx, rd1_idx;
    logic [1:0]      rd0_fmt, rd1_fmt;
    logic [FLEN-1:0] rd0_data, rd1_data;
    logic            rd0_err, rd1_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model [32];

    always #2 clk = ~clk;

    fpreg_file #(.FLEN(FLEN)) u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_fmt(rd0_fmt), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_fmt(rd1_fmt), .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    function automatic logic [63:0] exp_box(logic [1:0] f, logic [63:0] d);
        case (f)
            2'd0:    return {48'hFFFF_FFFF_FFFF, d[15:0]};
            2'd1:    return {32'hFFFF_FFFF, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(logic [1:0] f, logic [63:0] v);
        case (f)
            2'd0:    return (v[63:16] == 48'hFFFF_FFFF_FFFF) ? {48'h0, v[15:0]} : 64'h7E00;
            2'd1:    return (v[63:32] == 32'hFFFF_FFFF) ? {32'h0, v[31:0]} : 64'h7FC0_0000;
            2'd2:    return v;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [4:0] idx, logic [1:0] f, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_fmt = f; wr_data = d;
        #1;
        check("R7 wr_err", {63'h0, wr_err}, {63'h0, f == 2'd3});
        @(negedge clk);
        wr_en = 1'b0;
        if (f != 2'd3) model[idx] = exp_box(f, d);
    endtask

    task automatic rd_check(string tag, logic [4:0] i0, logic [1:0] f0, logic [4:0] i1, logic [1:0] f1);
        rd0_idx = i0; rd0_fmt = f0; rd1_idx = i1; rd1_fmt = f1;
        #1;
        check({tag, " port0"}, rd0_data, exp_read(f0, model[i0]));
        check({tag, " port1"}, rd1_data, exp_read(f1, model[i1]));
        check({tag, " err0 R7"}, {63'h0, rd0_err}, {63'h0, f0 == 2'd3});
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_fmt = '0; wr_data = '0;
        rd0_idx = '0; rd0_fmt = '0; rd1_idx = '0; rd1_fmt = '0;
        for (int i = 0; i < 32; i++) model[i] = '1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1: reset contents read as boxed ones in every format
        rd_check("R1 half/single", 5'd0, 2'd0, 5'd31, 2'd1);
        rd_check("R1 double", 5'd17, 2'd2, 5'd5, 2'd0);
        check("R1 half value", rd1_data, 64'hFFFF);

        // R2: half write boxed; upper data garbage ignored; single read passes it
        do_write(5'd1, 2'd0, 64'hDEAD_BEEF_CAFE_1234);
        rd_check("R2 half->single", 5'd1, 2'd1, 5'd1, 2'd2);
        check("R2 single value", rd0_data, 64'hFFFF_1234);
        check("R2 stored word", rd1_data, 64'hFFFF_FFFF_FFFF_1234);

        // R3 / R5: single write, half read gives canonical NaN
        do_write(5'd2, 2'd1, 64'h0123_4567_3F80_0000);
        rd_check("R3 single", 5'd2, 2'd2, 5'd2, 2'd0);
        check("R3 stored word", rd0_data, 64'hFFFF_FFFF_3F80_0000);
        check("R5 half canon", rd1_data, 64'h7E00);

        // R6 / R5: double unchanged, single read gives canonical NaN
        do_write(5'd3, 2'd2, 64'h4000_0000_0000_0001);
        rd_check("R6 double", 5'd3, 2'd2, 5'd3, 2'd1);
        check("R6 double value", rd0_data, 64'h4000_0000_0000_0001);
        check("R5 single canon", rd1_data, 64'h7FC0_0000);

        // R4: double with ones above bit 15 reads as valid half
        do_write(5'd4, 2'd2, 64'hFFFF_FFFF_FFFF_0042);
        rd_check("R4 half pass", 5'd4, 2'd0, 5'd4, 2'd1);
        check("R4 half value", rd0_data, 64'h0042);

        // R7 / R8: reserved write flagged and ignored
        do_write(5'd4, 2'd3, 64'h1111_2222_3333_4444);
        rd_check("R8 unchanged", 5'd4, 2'd2, 5'd4, 2'd3);
        check("R8 value", rd0_data, 64'hFFFF_FFFF_FFFF_0042);
        check("R7 err1", {63'h0, rd1_err}, 64'h1);

        // R9: same-cycle read sees old contents, new value after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd6; wr_fmt = 2'd2; wr_data = 64'hAAAA_5555_AAAA_5555;
        rd0_idx = 5'd6; rd0_fmt = 2'd2;
        #1;
        check("R9 old value", rd0_data, model[6]);
        @(negedge clk);
        wr_en = 1'b0;
        model[6] = 64'hAAAA_5555_AAAA_5555;
        #1;
        check("R9 new value", rd0_data, 64'hAAAA_5555_AAAA_5555);

        // R10 and random mix: random writes in all codes, random dual reads
        for (int k = 0; k < 400; k++) begin
            logic [4:0]  ri;
            logic [1:0]  rf;
            logic [63:0] rd;
            ri = 5'($urandom);
            rf = 2'($urandom);
            rd = {$urandom, $urandom};
            if (($urandom % 3) == 0) rd[63:32] = 32'hFFFF_FFFF;
            if (($urandom % 4) == 0) rd[31:16] = 16'hFFFF;
            do_write(ri, rf, rd);
            rd_check("R10 random", 5'($urandom), 2'($urandom), 5'($urandom), 2'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule